// File: doc/BRIEF.md
# Byte-Lane EDO DRAM Controller

This block sits between a synchronous host port and a 16-bit asynchronous EDO DRAM whose 9-bit address pins are shared between the row and the column. The host presents one request at a time: a read or a write, an 18-bit word address and a two-bit lane mask that picks the low byte, the high byte or the whole word. The controller splits the address into row and column. It sequences the row strobe, the two per-lane column strobes and the write and output enables. On a read it returns the data with a one-cycle valid pulse.

A free-running timer asks for a refresh at a fixed interval. The controller serves it as soon as the access in progress has finished, and before any waiting host request. A mode input picks between two refresh styles. In the first, the row strobe is pulsed with an internally counted row address while both column strobes stay high. In the second, both column strobes fall first and the row strobe follows, and the DRAM uses its own refresh address. Every strobe phase lasts a number of clock cycles set by a parameter.

Top module: `edo_lane_ctrl`

## Requirements
- R1: During reset and whenever the controller is idle, `ras_n`, both bits of `col_stb_n`, `we_n` and `oe_n` are high and `dq_oe` is low.
- R2: The word address is sent as row `req_addr[17:9]` on `dram_addr` while `ras_n` falls, then as column `req_addr[8:0]` while the column strobes fall. Data written at one address reads back from that address and from no other.
- R3: `req_mask[0]` selects the low lane (`col_stb_n[0]`, data bits 7:0) and `req_mask[1]` selects the high lane (`col_stb_n[1]`, bits 15:8). A write to one lane leaves the other lane of that word unchanged.
- R4: A read drives `oe_n` low and `we_n` high during the column phase. It then raises `rd_valid` for exactly one cycle, with unselected lanes of `rd_data` returned as zero. Reads complete in request order.
- R5: A write drives `we_n` low, `oe_n` high and `dq_oe` high while the column strobes are low.
- R6: `ras_n` stays low for at least `T_RCD` cycles before a column strobe falls. A column strobe stays low for at least `T_CAS` cycles. `ras_n` stays high for at least `T_RP` cycles before it falls.
- R7: With `ref_cbr` low, a refresh drops `ras_n` with both column strobes high and no enable active. The row on `dram_addr` comes from a 9-bit counter that starts at 0 after reset and rises by one, modulo 512, after each such refresh.
- R8: With `ref_cbr` high, a refresh drops both column strobes at least `T_CSR` cycles before `ras_n` falls, with `we_n` high. This style leaves the internal row counter unchanged.
- R9: With no host traffic, refreshes start exactly `REF_INTERVAL` cycles apart.
- R10: A pending refresh is started before any new host request, so under continuous traffic successive refreshes are at most `REF_INTERVAL + T_RCD + T_CAS + T_RP + 1` cycles apart.
- R11: A request with mask `00` asserts no column strobe. A read with mask `00` returns zero, and a write with mask `00` changes no stored data.
- R12: `req_ready` is high only while the controller is idle with no refresh pending. A request is taken on a cycle where `req_valid` and `req_ready` are both high, and `req_ready` is low on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address, row in the upper 9 bits |
| req_mask | input | 2 | Lane select, bit 0 low byte, bit 1 high byte |
| req_wdata | input | 16 | Write data |
| rd_valid | output | 1 | One-cycle pulse with read data |
| rd_data | output | 16 | Read data, unselected lanes zero |
| ref_cbr | input | 1 | Refresh style: 0 row-only, 1 column-before-row |
| dram_addr | output | 9 | Multiplexed row/column address |
| ras_n | output | 1 | Row strobe, active low |
| col_stb_n | output | 2 | Column strobes, bit 0 low lane, bit 1 high lane, active low |
| we_n | output | 1 | Write enable, active low |
| oe_n | output | 1 | Output enable, active low |
| dq_out | output | 16 | Data driven toward the DRAM |
| dq_oe | output | 1 | Drive enable for `dq_out` |
| dq_in | input | 16 | Data returned by the DRAM |

## Verification
The hardest case to reach from the ports is a refresh request that lands while a host access is part way through its phases. The refresh must then wait for the access and win over the next request. The timer runs on its own, so the bench keeps requests back to back for many refresh intervals and lets the ticks fall on every phase. It then bounds the spacing of refresh starts. A second subtle case is telling a mask-`00` access apart from a row-only refresh on the pins. The bench's DRAM model classifies each row-strobe pulse by whether any column strobe or enable moved inside it. The model also checks that the refresh row sequence continues without a gap across a spell of column-before-row refreshes.

// File: rtl/edo_pkg.sv
package edo_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROW,
    ST_COL,
    ST_PRE,
    ST_ROR,
    ST_CBRC,
    ST_CBRR
  } edo_state_e;

  function automatic int unsigned tmax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // A phase of len cycles ends on the cycle whose index is len-1.
  function automatic logic phase_last(input int unsigned idx, input int unsigned len);
    return (idx + 1) >= len;
  endfunction

endpackage

// File: rtl/edo_ref_timer.sv
module edo_ref_timer #(
  parameter int unsigned INTERVAL = 780
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ack,
  output logic pend
);
  localparam int unsigned TW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;

  logic [TW-1:0] cnt;
  logic          tick;

  assign tick = (cnt == TW'(INTERVAL - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      pend <= 1'b0;
    end else begin
      cnt <= tick ? '0 : cnt + TW'(1);
      if (ack)  pend <= 1'b0;
      if (tick) pend <= 1'b1;
    end
  end
endmodule

// File: rtl/edo_row_ctr.sv
module edo_row_ctr #(
  parameter int unsigned ROW_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [ROW_W-1:0] row
);
  function automatic logic [ROW_W-1:0] row_next(input logic [ROW_W-1:0] r);
    return r + ROW_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)   row <= '0;
    else if (inc) row <= row_next(row);
  end
endmodule

// File: rtl/edo_seq.sv
module edo_seq
  import edo_pkg::*;
#(
  parameter int unsigned ROW_W  = 9,
  parameter int unsigned COL_W  = 9,
  parameter int unsigned LANE_W = 8,
  parameter int unsigned LANES  = 2,
  parameter int unsigned T_RCD  = 2,
  parameter int unsigned T_CAS  = 2,
  parameter int unsigned T_RP   = 3,
  parameter int unsigned T_CSR  = 1,
  parameter int unsigned T_RREF = 4,
  localparam int unsigned ADDR_W = ROW_W + COL_W,
  localparam int unsigned DATA_W = LANE_W * LANES,
  localparam int unsigned MA_W   = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LANES-1:0]  req_mask,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  input  logic              ref_pend,
  input  logic              ref_cbr,
  input  logic [ROW_W-1:0]  ref_row,
  output logic              ref_ack,
  output logic              ror_done,
  output logic [MA_W-1:0]   dram_addr,
  output logic              ras_n,
  output logic [LANES-1:0]  col_stb_n,
  output logic              we_n,
  output logic              oe_n,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  input  logic [DATA_W-1:0] dq_in,
  output logic              idle_o,
  output logic              ref_busy_o,
  output logic              ror_o
);
  localparam int unsigned MAX_T = tmax(tmax(T_RCD, T_CAS), tmax(tmax(T_RP, T_CSR), T_RREF));
  localparam int unsigned CNT_W = $clog2(MAX_T + 1);

  function automatic int unsigned len_of(input edo_state_e s);
    case (s)
      ST_ROW:  return T_RCD;
      ST_COL:  return T_CAS;
      ST_PRE:  return T_RP;
      ST_ROR:  return T_RREF;
      ST_CBRC: return T_CSR;
      ST_CBRR: return T_RREF;
      default: return 1;
    endcase
  endfunction

  function automatic logic [MA_W-1:0] row_of(input logic [ADDR_W-1:0] a);
    return MA_W'(a[ADDR_W-1:COL_W]);
  endfunction

  function automatic logic [MA_W-1:0] col_of(input logic [ADDR_W-1:0] a);
    return MA_W'(a[COL_W-1:0]);
  endfunction

  edo_state_e        state, state_d;
  logic [CNT_W-1:0]  cnt, cnt_d;
  logic              accept, ph_end;
  logic              op_write, op_write_d;
  logic [ADDR_W-1:0] op_addr, op_addr_d;
  logic [LANES-1:0]  op_mask, op_mask_d;
  logic [DATA_W-1:0] op_wdata, op_wdata_d;
  logic              ras_d, we_d, oe_d, dqoe_d;
  logic [LANES-1:0]  cas_d;
  logic [MA_W-1:0]   addr_d;

  assign ph_end     = phase_last(int'(cnt), len_of(state));
  assign req_ready  = (state == ST_IDLE) && !ref_pend;
  assign idle_o     = (state == ST_IDLE);
  assign ror_o      = (state == ST_ROR);
  assign ref_busy_o = (state == ST_ROR) || (state == ST_CBRC) || (state == ST_CBRR);

  // Phase sequencing.
  always_comb begin
    state_d  = state;
    cnt_d    = cnt + CNT_W'(1);
    accept   = 1'b0;
    ref_ack  = 1'b0;
    ror_done = 1'b0;
    case (state)
      ST_IDLE: begin
        cnt_d = '0;
        if (ref_pend) begin
          ref_ack = 1'b1;
          state_d = ref_cbr ? ST_CBRC : ST_ROR;
        end else if (req_valid) begin
          accept  = 1'b1;
          state_d = ST_ROW;
        end
      end
      ST_ROW:  if (ph_end) state_d = ST_COL;
      ST_COL:  if (ph_end) state_d = ST_PRE;
      ST_PRE:  if (ph_end) state_d = ST_IDLE;
      ST_ROR:  if (ph_end) begin state_d = ST_PRE; ror_done = 1'b1; end
      ST_CBRC: if (ph_end) state_d = ST_CBRR;
      ST_CBRR: if (ph_end) state_d = ST_PRE;
      default: state_d = ST_PRE;
    endcase
    if (state_d != state) cnt_d = '0;
  end

  assign op_write_d = accept ? req_write : op_write;
  assign op_addr_d  = accept ? req_addr  : op_addr;
  assign op_mask_d  = accept ? req_mask  : op_mask;
  assign op_wdata_d = accept ? req_wdata : op_wdata;

  // Pin values for the coming cycle, decoded from the next phase.
  always_comb begin
    ras_d  = 1'b1;
    cas_d  = '1;
    we_d   = 1'b1;
    oe_d   = 1'b1;
    dqoe_d = 1'b0;
    addr_d = dram_addr;
    case (state_d)
      ST_ROW: begin
        ras_d  = 1'b0;
        addr_d = row_of(op_addr_d);
      end
      ST_COL: begin
        ras_d  = 1'b0;
        cas_d  = ~op_mask_d;
        addr_d = col_of(op_addr_d);
        we_d   = ~op_write_d;
        oe_d   = op_write_d;
        dqoe_d = op_write_d;
      end
      ST_ROR: begin
        ras_d  = 1'b0;
        addr_d = MA_W'(ref_row);
      end
      ST_CBRC: cas_d = '0;
      ST_CBRR: begin
        cas_d = '0;
        ras_d = 1'b0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_PRE;
      cnt       <= '0;
      op_write  <= 1'b0;
      op_addr   <= '0;
      op_mask   <= '0;
      op_wdata  <= '0;
      ras_n     <= 1'b1;
      col_stb_n <= '1;
      we_n      <= 1'b1;
      oe_n      <= 1'b1;
      dq_oe     <= 1'b0;
      dq_out    <= '0;
      dram_addr <= '0;
      rd_valid  <= 1'b0;
    end else begin
      state     <= state_d;
      cnt       <= cnt_d;
      op_write  <= op_write_d;
      op_addr   <= op_addr_d;
      op_mask   <= op_mask_d;
      op_wdata  <= op_wdata_d;
      ras_n     <= ras_d;
      col_stb_n <= cas_d;
      we_n      <= we_d;
      oe_n      <= oe_d;
      dq_oe     <= dqoe_d;
      dq_out    <= op_wdata_d;
      dram_addr <= addr_d;
      rd_valid  <= (state == ST_COL) && ph_end && !op_write;
    end
  end

  // Per-lane read capture at the last cycle of the column phase.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n)
        rd_data[g*LANE_W +: LANE_W] <= '0;
      else if ((state == ST_COL) && ph_end && !op_write)
        rd_data[g*LANE_W +: LANE_W] <= op_mask[g] ? dq_in[g*LANE_W +: LANE_W] : '0;
    end
  end
endmodule

// File: rtl/edo_lane_ctrl.sv
module edo_lane_ctrl #(
  parameter int unsigned ROW_W        = 9,
  parameter int unsigned COL_W        = 9,
  parameter int unsigned LANE_W       = 8,
  parameter int unsigned LANES        = 2,
  parameter int unsigned T_RCD        = 2,
  parameter int unsigned T_CAS        = 2,
  parameter int unsigned T_RP         = 3,
  parameter int unsigned T_CSR        = 1,
  parameter int unsigned T_RREF       = 4,
  parameter int unsigned REF_INTERVAL = 780
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   req_valid,
  output logic                                   req_ready,
  input  logic                                   req_write,
  input  logic [ROW_W+COL_W-1:0]                 req_addr,
  input  logic [LANES-1:0]                       req_mask,
  input  logic [LANE_W*LANES-1:0]                req_wdata,
  output logic                                   rd_valid,
  output logic [LANE_W*LANES-1:0]                rd_data,
  input  logic                                   ref_cbr,
  output logic [((ROW_W>COL_W)?ROW_W:COL_W)-1:0] dram_addr,
  output logic                                   ras_n,
  output logic [LANES-1:0]                       col_stb_n,
  output logic                                   we_n,
  output logic                                   oe_n,
  output logic [LANE_W*LANES-1:0]                dq_out,
  output logic                                   dq_oe,
  input  logic [LANE_W*LANES-1:0]                dq_in
);
  // Internal events brought out for the checker.
  logic             ref_pend_w;
  logic             ref_ack_w;
  logic             ror_done_w;
  logic             idle_w;
  logic             ref_busy_w;
  logic             ror_w;
  logic [ROW_W-1:0] ref_row_w;

  edo_ref_timer #(.INTERVAL(REF_INTERVAL)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .ack  (ref_ack_w),
    .pend (ref_pend_w)
  );

  edo_row_ctr #(.ROW_W(ROW_W)) u_rowctr (
    .clk  (clk),
    .rst_n(rst_n),
    .inc  (ror_done_w),
    .row  (ref_row_w)
  );

  edo_seq #(
    .ROW_W(ROW_W), .COL_W(COL_W), .LANE_W(LANE_W), .LANES(LANES),
    .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RP(T_RP), .T_CSR(T_CSR), .T_RREF(T_RREF)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_mask  (req_mask),
    .req_wdata (req_wdata),
    .req_ready (req_ready),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .ref_pend  (ref_pend_w),
    .ref_cbr   (ref_cbr),
    .ref_row   (ref_row_w),
    .ref_ack   (ref_ack_w),
    .ror_done  (ror_done_w),
    .dram_addr (dram_addr),
    .ras_n     (ras_n),
    .col_stb_n (col_stb_n),
    .we_n      (we_n),
    .oe_n      (oe_n),
    .dq_out    (dq_out),
    .dq_oe     (dq_oe),
    .dq_in     (dq_in),
    .idle_o    (idle_w),
    .ref_busy_o(ref_busy_w),
    .ror_o     (ror_w)
  );
endmodule

// File: rtl/edo_lane_chk.sv
module edo_lane_chk #(
  parameter int unsigned LANES = 2,
  parameter int unsigned T_RCD = 2,
  parameter int unsigned T_CAS = 2,
  parameter int unsigned T_RP  = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ras_n,
  input logic [LANES-1:0] col_stb_n,
  input logic             we_n,
  input logic             oe_n,
  input logic             dq_oe,
  input logic             rd_valid,
  input logic             req_ready,
  input logic             idle_w,
  input logic             ref_pend_w,
  input logic             ref_busy_w,
  input logic             ror_w
);
  logic [15:0] ras_lo_run, ras_hi_run, cas_lo_run;
  logic        any_cas;

  assign any_cas = (col_stb_n != '1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ras_lo_run <= '0;
      ras_hi_run <= '0;
      cas_lo_run <= '0;
    end else begin
      ras_lo_run <= ras_n ? '0 : ((&ras_lo_run) ? ras_lo_run : ras_lo_run + 16'd1);
      ras_hi_run <= !ras_n ? '0 : ((&ras_hi_run) ? ras_hi_run : ras_hi_run + 16'd1);
      cas_lo_run <= !any_cas ? '0 : ((&cas_lo_run) ? cas_lo_run : cas_lo_run + 16'd1);
    end
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle_w |-> (ras_n && (col_stb_n == '1) && we_n && oe_n && !dq_oe));

  // R5
  dir_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !oe_n));

  // R6
  rcd_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(any_cas) && !ras_n) |-> (ras_lo_run >= 16'(T_RCD)));

  // R6
  rp_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (ras_hi_run >= 16'(T_RP)));

  // R6
  cas_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(any_cas) && ($past(!we_n) || $past(!oe_n))) |-> (cas_lo_run >= 16'(T_CAS)));

  // R7
  ror_no_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ror_w |-> ((col_stb_n == '1) && we_n && oe_n));

  // R8
  cbr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && any_cas) |-> (($past(col_stb_n) == '0) && (col_stb_n == '0) && we_n));

  // R10
  ref_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_w && ref_pend_w) |=> ref_busy_w);

  // R4
  rdv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  // R12
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (idle_w && !ref_pend_w));
endmodule

bind edo_lane_ctrl edo_lane_chk #(
  .LANES(LANES), .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RP(T_RP)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ras_n     (ras_n),
  .col_stb_n (col_stb_n),
  .we_n      (we_n),
  .oe_n      (oe_n),
  .dq_oe     (dq_oe),
  .rd_valid  (rd_valid),
  .req_ready (req_ready),
  .idle_w    (idle_w),
  .ref_pend_w(ref_pend_w),
  .ref_busy_w(ref_busy_w),
  .ror_w     (ror_w)
);

// File: tb/edo_lane_ctrl_bench.sv
`timescale 1ns/1ps
module edo_lane_ctrl_bench;
  localparam int T_RCD = 2, T_CAS = 2, T_RP = 2, T_CSR = 1, T_RREF = 3;
  localparam int REF_INT = 64;
  localparam int GAP_MAX = REF_INT + T_RCD + T_CAS + T_RP + 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, ref_cbr = 1'b0;
  logic [17:0] req_addr = '0;
  logic [1:0]  req_mask = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ready, rd_valid, ras_n, we_n, oe_n, dq_oe;
  logic [15:0] rd_data, dq_out;
  logic [15:0] dq_in = 16'hA5A5;
  logic [1:0]  col_stb_n;
  logic [8:0]  dram_addr;

  always #4 clk = ~clk;

  edo_lane_ctrl #(
    .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RP(T_RP), .T_CSR(T_CSR), .T_RREF(T_RREF),
    .REF_INTERVAL(REF_INT)
  ) u_edo_lane_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_mask(req_mask),
    .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .ref_cbr(ref_cbr), .dram_addr(dram_addr), .ras_n(ras_n),
    .col_stb_n(col_stb_n), .we_n(we_n), .oe_n(oe_n), .dq_out(dq_out),
    .dq_oe(dq_oe), .dq_in(dq_in)
  );

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Reference contents kept by the driver, and the DRAM model's own array.
  logic [15:0] ref_mem [int];
  logic [15:0] dram    [int];
  logic [15:0] exp_q   [$];

  function automatic logic [15:0] pick(input logic [15:0] v, input logic [1:0] m);
    return {(m[1] ? v[15:8] : 8'h00), (m[0] ? v[7:0] : 8'h00)};
  endfunction

  // ---------------- DRAM model, observed away from the active edge -------------
  int   cyc = 0;
  bit   p_ras = 1'b1;
  logic [1:0] p_cas = 2'b11;
  int   ras_lo_run = 0, ras_hi_run = 0, cas_lo_run = 0;
  logic [8:0] row_l = '0;
  bit   cas_seen = 0, op_seen = 0, in_cbr = 0;
  int   fall_cyc = 0;
  int   exp_row = 0, ror_cnt = 0, cbr_cnt = 0, total_ref = 0;
  int   last_ref = 0, last_gap = 0, max_gap = 0;
  bit   have_last = 0, traffic = 0;

  task automatic note_ref(input int at);
    if (have_last) begin
      last_gap = at - last_ref;
      if (traffic && last_gap > max_gap) max_gap = last_gap;
    end
    last_ref  = at;
    have_last = 1;
    total_ref++;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (!ras_n && (!we_n || !oe_n)) op_seen = 1;
      if (p_ras && !ras_n) begin
        chk(ras_hi_run >= T_RP, "R6 precharge before row fall", ras_hi_run, T_RP);
        cas_seen = 0;
        op_seen  = !we_n || !oe_n;
        fall_cyc = cyc;
        if (col_stb_n == 2'b11) begin
          row_l = dram_addr;
        end else if (col_stb_n == 2'b00) begin
          chk(p_cas == 2'b00, "R8 column strobes low before row strobe", p_cas, 0);
          chk(cas_lo_run >= T_CSR, "R8 column-first setup", cas_lo_run, T_CSR);
          chk(we_n, "R8 write enable high", we_n, 1);
          in_cbr = 1;
          cbr_cnt++;
          note_ref(cyc);
        end else begin
          chk(0, "R8 single column strobe at row fall", col_stb_n, 0);
        end
      end
      if (!ras_n && !p_ras && !in_cbr && ((p_cas & ~col_stb_n) != 2'b00)) begin
        cas_seen = 1;
        chk(ras_lo_run >= T_RCD, "R6 row to column delay", ras_lo_run, T_RCD);
        if (!we_n) begin
          chk(oe_n && dq_oe, "R5 write enables", {oe_n, dq_oe}, 2'b11);
          begin
            logic [15:0] old;
            int key;
            key = int'({row_l, dram_addr});
            old = dram.exists(key) ? dram[key] : 16'h0;
            if (!col_stb_n[0]) old[7:0]  = dq_out[7:0];
            if (!col_stb_n[1]) old[15:8] = dq_out[15:8];
            dram[key] = old;
          end
        end else begin
          chk(!oe_n, "R4 read output enable", oe_n, 0);
        end
      end
      if (!p_ras && ras_n) begin
        if (!in_cbr && !cas_seen && !op_seen) begin
          chk(row_l == 9'(exp_row), "R7 refresh row sequence", row_l, exp_row);
          exp_row = (exp_row + 1) % 512;
          ror_cnt++;
          note_ref(fall_cyc);
        end
        in_cbr = 0;
      end
      // Read data presented by the model; unselected lanes carry junk.
      begin
        logic [15:0] v;
        int key;
        key = int'({row_l, dram_addr});
        v = dram.exists(key) ? dram[key] : 16'h0;
        dq_in[7:0]  = (!ras_n && !oe_n && !col_stb_n[0]) ? v[7:0]  : 8'hA5;
        dq_in[15:8] = (!ras_n && !oe_n && !col_stb_n[1]) ? v[15:8] : 8'h5A;
      end
      ras_lo_run = ras_n ? 0 : ras_lo_run + 1;
      ras_hi_run = ras_n ? ras_hi_run + 1 : 0;
      cas_lo_run = (col_stb_n == 2'b00) ? cas_lo_run + 1 : 0;
      p_ras = ras_n;
      p_cas = col_stb_n;
    end
  end

  // ---------------- Scoreboard monitor ----------------
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        chk(0, "R4 unexpected read data", rd_data, 0);
      end else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        chk(rd_data == e, "R4 R2 R3 read data", rd_data, e);
      end
    end
  end

  // ---------------- Driver ----------------
  task automatic do_op(input bit wr, input logic [17:0] a, input logic [1:0] m,
                       input logic [15:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_mask = m; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R12 ready low after accept", req_ready, 0);
    if (wr) begin
      logic [15:0] old;
      old = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 16'h0;
      if (m[0]) old[7:0]  = d[7:0];
      if (m[1]) old[15:8] = d[15:8];
      ref_mem[int'(a)] = old;
    end else begin
      exp_q.push_back(pick(ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 16'h0, m));
    end
  endtask

  task automatic drain();
    int n = 0;
    while (exp_q.size() != 0 && n < 200) begin @(negedge clk); n++; end
    chk(exp_q.size() == 0, "R4 all reads returned", exp_q.size(), 0);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: pins quiet during reset
    chk(ras_n && we_n && oe_n && col_stb_n == 2'b11 && !dq_oe && !rd_valid,
        "R1 pins during reset", {ras_n, col_stb_n, we_n, oe_n, dq_oe}, 6'b111110);
    rst_n = 1'b1;
    repeat (T_RP + 2) @(negedge clk);
    chk(ras_n && we_n && oe_n && col_stb_n == 2'b11 && !dq_oe,
        "R1 pins idle after reset", {ras_n, col_stb_n, we_n, oe_n, dq_oe}, 6'b111110);
    chk(req_ready, "R12 ready when idle", req_ready, 1);

    // R2: corner addresses, differing only in row or only in column
    do_op(1, 18'h00000, 2'b11, 16'h1111);
    do_op(1, 18'h3FFFF, 2'b11, 16'hFFEE);
    do_op(1, 18'h001FF, 2'b11, 16'h2222);
    do_op(1, 18'h3FE00, 2'b11, 16'h3333);
    do_op(1, 18'h00200, 2'b11, 16'h4444);
    do_op(0, 18'h00000, 2'b11, 0);
    do_op(0, 18'h3FFFF, 2'b11, 0);
    do_op(0, 18'h001FF, 2'b11, 0);
    do_op(0, 18'h3FE00, 2'b11, 0);
    do_op(0, 18'h00200, 2'b11, 0);

    // R3: lane writes leave the other lane alone
    do_op(1, 18'h12345, 2'b11, 16'hABCD);
    do_op(1, 18'h12345, 2'b01, 16'h0077);
    do_op(0, 18'h12345, 2'b11, 0);
    do_op(1, 18'h12345, 2'b10, 16'h9900);
    do_op(0, 18'h12345, 2'b11, 0);
    // R4: byte reads return zero in the unselected lane
    do_op(0, 18'h12345, 2'b01, 0);
    do_op(0, 18'h12345, 2'b10, 0);
    // R11: empty mask
    do_op(0, 18'h12345, 2'b00, 0);
    do_op(1, 18'h12345, 2'b00, 16'h0000);
    do_op(0, 18'h12345, 2'b11, 0);
    drain();

    // R10: back-to-back traffic across many refresh intervals
    traffic = 1;
    for (int i = 0; i < 60; i++) begin
      logic [17:0] a;
      a = 18'(i * 18'h0A3C5 + 7);
      do_op(1, a, 2'(i % 3 + 1), 16'(i * 16'h1357 + 16'h2468));
      do_op(0, a, 2'b11, 0);
    end
    traffic = 0;
    drain();
    chk(max_gap > 0 && max_gap <= GAP_MAX, "R10 refresh spacing under traffic", max_gap, GAP_MAX);

    // R9: quiet spacing
    begin
      int n0;
      n0 = total_ref;
      wait (total_ref >= n0 + 3);
      chk(last_gap == REF_INT, "R9 idle refresh interval", last_gap, REF_INT);
    end
    chk(ror_cnt > 0, "R7 row-only refreshes seen", ror_cnt, 1);

    // R8: column-before-row style
    begin
      int ror0;
      ror0 = ror_cnt;
      @(negedge clk); ref_cbr = 1'b1;
      repeat (3 * REF_INT + 10) @(negedge clk);
      chk(cbr_cnt >= 2, "R8 column-first refreshes seen", cbr_cnt, 2);
      chk(ror_cnt == ror0, "R8 no row-only refresh in column-first mode", ror_cnt, ror0);
      do_op(1, 18'h2AAAA, 2'b11, 16'h5AA5);
      do_op(0, 18'h2AAAA, 2'b11, 0);
      do_op(0, 18'h12345, 2'b11, 0);
      drain();
      // R7: row counter resumes where it stopped
      @(negedge clk); ref_cbr = 1'b0;
      repeat (2 * REF_INT + 10) @(negedge clk);
      chk(ror_cnt >= ror0 + 1, "R7 row-only refresh resumes", ror_cnt, ror0 + 1);
    end

    chk(exp_q.size() == 0, "R4 scoreboard empty at end", exp_q.size(), 0);
    finish_run();
  end
endmodule